// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital half of a charge-redistribution successive approximation converter. It receives a start pulse and then runs a sampling phase. During that phase the capacitor top plate is held at common mode and the bottom plates track the input. The top plate is then left floating, and the block performs a binary search from the most significant bit downward. Each bit of the trial word drives one bottom-plate switch: a 1 selects the reference and a 0 selects ground. Every trial cycle raises a comparator strobe, and the comparator's decision is taken at the clock edge that closes that cycle.

The search length is chosen at start time. It can cover the full word or stop 2, 4 or 6 bits early, which gives 12, 10, 8 or 6 bits at the default width. A shorter search saves one clock per bit that is dropped. The result stays aligned to the top of the output word, and the bits that were never tried read zero. A busy flag covers the conversion, and a single-cycle done pulse marks the cycle in which the result becomes valid.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, busy, done, sample_phase and cmp_strobe are 0, and cap_sw and result are all zeros.
- R2: A start that is accepted holds sample_phase high for max(samp_cycles,1) cycles. During that time cap_sw is zero and cmp_strobe is low.
- R3: The first trial cycle drives cap_sw with only the top bit set (100000000000 at width 12).
- R4: In each trial cycle cmp_strobe is high. At the closing edge, cmp_out=1 keeps the trial bit and cmp_out=0 clears it. The next lower bit is then set, and bits that are already resolved do not change.
- R5: res_sel encodes the search length: 0 gives 12 bits, 1 gives 10, 2 gives 8 and 3 gives 6. cmp_strobe is high for exactly that many cycles per conversion.
- R6: result is MSB-aligned and equals the held input level truncated to the selected length. Its low 2*res_sel bits read 0.
- R7: res_sel and samp_cycles are captured when a start is accepted. A later change has no effect on the conversion in progress.
- R8: busy rises in the cycle after the accepting edge and stays high until the last decision. done is high for exactly one cycle, with busy low and result valid. From the accepting edge through the edge that raises done, max(samp_cycles,1)+N+1 edges pass.
- R9: A start pulse that arrives while busy is high is ignored. No second conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, accepted only while idle |
| res_sel | input | 2 | Search length select (0:12, 1:10, 2:8, 3:6 bits) |
| samp_cycles | input | 8 | Sampling phase length in cycles, 0 treated as 1 |
| cmp_out | input | 1 | Comparator decision, 1 = input above trial level |
| sample_phase | output | 1 | Top plate at common mode, bottom plates tracking input |
| cmp_strobe | output | 1 | Comparator enable, high in every trial cycle |
| cap_sw | output | 12 | Bottom-plate switch selects, 1 = reference, 0 = ground |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 12 | MSB-aligned conversion result |

## Verification
The bench replaces the analog array with an ideal comparator. The comparator holds the input code while sample_phase is high and compares it against cap_sw. The bench covers the all-ones and all-zeros inputs, both ends of the sampling count (including zero), and every search length. If a design miscounted the stop bit, it would leave a stray low bit set or convert one bit too many, and both the result and the latency checks would catch this. Some conversions change res_sel and pulse start while busy. A design that did not capture the select at start would then truncate in the middle of the search, and one that accepted the extra start would raise busy again after done.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_TRIAL  = 2'd2
  } phase_t;
endpackage

// File: rtl/sar_phase_fsm.sv
module sar_phase_fsm
  import sar_seq_pkg::*;
#(
  parameter int WIDTH  = 12,
  parameter int SAMP_W = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        res_sel,
  input  logic [SAMP_W-1:0] samp_cycles,
  output phase_t            phase,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              load_msb,
  output logic              last_bit
);
  logic [SAMP_W-1:0] samp_left;
  logic [IDX_W-1:0]  stop_idx;

  assign load_msb = (phase == PH_SAMPLE) && (samp_left == SAMP_W'(1));
  assign last_bit = (phase == PH_TRIAL) && (bit_idx == stop_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      samp_left <= '0;
      bit_idx   <= '0;
      stop_idx  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase     <= PH_SAMPLE;
          samp_left <= (samp_cycles == '0) ? SAMP_W'(1) : samp_cycles;
          stop_idx  <= IDX_W'({res_sel, 1'b0});
        end
        PH_SAMPLE: begin
          if (load_msb) begin
            phase   <= PH_TRIAL;
            bit_idx <= IDX_W'(WIDTH - 1);
          end else begin
            samp_left <= samp_left - 1'b1;
          end
        end
        PH_TRIAL: begin
          if (last_bit) phase <= PH_IDLE;
          else          bit_idx <= bit_idx - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int WIDTH = 12,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_msb,
  input  logic             step,
  input  logic             last_bit,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             cmp_out,
  output logic [WIDTH-1:0] cap_sw,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  logic [WIDTH-1:0] decided;

  always_comb begin
    decided          = cap_sw;
    decided[bit_idx] = cmp_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_sw <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= step && last_bit;
      if (load_msb) begin
        cap_sw <= {1'b1, {(WIDTH-1){1'b0}}};
      end else if (step) begin
        if (last_bit) begin
          result <= decided;
          cap_sw <= '0;
        end else begin
          cap_sw <= decided | (WIDTH'(1) << (bit_idx - 1'b1));
        end
      end
    end
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int WIDTH  = 12,
  parameter int SAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        res_sel,
  input  logic [SAMP_W-1:0] samp_cycles,
  input  logic              cmp_out,
  output logic              sample_phase,
  output logic              cmp_strobe,
  output logic [WIDTH-1:0]  cap_sw,
  output logic              busy,
  output logic              done,
  output logic [WIDTH-1:0]  result
);
  localparam int IDX_W = $clog2(WIDTH);

  phase_t           phase;
  logic [IDX_W-1:0] bit_idx;
  logic             load_msb;
  logic             last_bit;

  sar_phase_fsm #(.WIDTH(WIDTH), .SAMP_W(SAMP_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .res_sel(res_sel),
    .samp_cycles(samp_cycles), .phase(phase), .bit_idx(bit_idx),
    .load_msb(load_msb), .last_bit(last_bit)
  );

  sar_trial_reg #(.WIDTH(WIDTH)) u_trial (
    .clk(clk), .rst(rst), .load_msb(load_msb),
    .step(phase == PH_TRIAL), .last_bit(last_bit), .bit_idx(bit_idx),
    .cmp_out(cmp_out), .cap_sw(cap_sw), .result(result), .done(done)
  );

  assign busy         = (phase != PH_IDLE);
  assign sample_phase = (phase == PH_SAMPLE);
  assign cmp_strobe   = (phase == PH_TRIAL);
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int WIDTH  = 12,
  parameter int SAMP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [1:0]        res_sel,
  input logic              sample_phase,
  input logic              cmp_strobe,
  input logic [WIDTH-1:0]  cap_sw,
  input logic              busy,
  input logic              done,
  input logic [WIDTH-1:0]  result
);
  logic [1:0] sel_q;
  logic [7:0] strobe_cnt;
  logic [WIDTH-1:0] low_mask;

  assign low_mask = ~({WIDTH{1'b1}} << {sel_q, 1'b0});

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= '0;
      strobe_cnt <= '0;
    end else if (start && !busy) begin
      sel_q      <= res_sel;
      strobe_cnt <= '0;
    end else if (cmp_strobe) begin
      strobe_cnt <= strobe_cnt + 1'b1;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R2
  sample_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sample_phase |-> (cap_sw == '0) && !cmp_strobe);
  // R3
  first_trial_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_strobe) |-> cap_sw == {1'b1, {(WIDTH-1){1'b0}}});
  // R4
  one_new_bit_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_strobe && $past(cmp_strobe) |-> $countones(cap_sw & ~$past(cap_sw)) == 1);
  // R5
  strobe_count_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> strobe_cnt == 8'(WIDTH - 2 * int'(sel_q)));
  // R6
  low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (result & low_mask) == '0);
endmodule

bind sar_seq_ctrl sar_seq_chk #(.WIDTH(WIDTH), .SAMP_W(SAMP_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .res_sel(res_sel),
  .sample_phase(sample_phase), .cmp_strobe(cmp_strobe), .cap_sw(cap_sw),
  .busy(busy), .done(done), .result(result)
);

// File: tb/sar_seq_ctrl_tb.sv
module sar_seq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  res_sel = 2'd0;
  logic [7:0]  samp_cycles = 8'd1;
  logic        cmp_out;
  logic        sample_phase, cmp_strobe, busy, done;
  logic [11:0] cap_sw, result;
  logic [11:0] vin_live = '0;
  logic [11:0] vin_held = '0;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sar_seq_ctrl u_dut (
    .clk(clk), .rst(rst), .start(start), .res_sel(res_sel),
    .samp_cycles(samp_cycles), .cmp_out(cmp_out), .sample_phase(sample_phase),
    .cmp_strobe(cmp_strobe), .cap_sw(cap_sw), .busy(busy), .done(done),
    .result(result)
  );

  // ideal comparator with a held sample
  always @(negedge clk) if (sample_phase) vin_held <= vin_live;
  assign cmp_out = (vin_held >= cap_sw);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {disturb, sel, samp, code}
  localparam int NV = 9;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'd1, 12'h8B9},
    {1'b0, 2'd0, 8'd3, 12'hFFF},
    {1'b0, 2'd0, 8'd2, 12'h000},
    {1'b0, 2'd1, 8'd0, 12'h8B9},
    {1'b1, 2'd2, 8'd4, 12'hA5C},
    {1'b0, 2'd3, 8'd1, 12'hFFF},
    {1'b1, 2'd3, 8'd2, 12'h03F},
    {1'b1, 2'd1, 8'd5, 12'h7FF},
    {1'b0, 2'd2, 8'd1, 12'h800}
  };

  task automatic run_conv(input logic [1:0] sel, input logic [7:0] samp,
                          input logic [11:0] code, input bit disturb);
    int cycles, samp_seen, strobes, n_bits, s_eff;
    logic [11:0] exp_res;
    n_bits  = 12 - 2 * int'(sel);
    s_eff   = (samp == 0) ? 1 : int'(samp);
    exp_res = code & ~((12'd1 << (2 * sel)) - 12'd1);
    vin_live = code;
    @(negedge clk);
    start = 1'b1; res_sel = sel; samp_cycles = samp;
    @(negedge clk);
    start = 1'b0;
    cycles = 1; samp_seen = 0; strobes = 0;
    check(busy === 1'b1, "R8 busy after start", busy, 1);
    while (!done && cycles < 200) begin
      if (sample_phase) begin
        samp_seen++;
        check(cap_sw == 0 && !cmp_strobe, "R2 quiet sampling", cap_sw, 0);
      end
      if (cmp_strobe) begin
        strobes++;
        if (strobes == 1) check(cap_sw == 12'h800, "R3 first trial", cap_sw, 12'h800);
      end
      if (disturb && cycles == 2) begin
        res_sel = ~sel; samp_cycles = 8'd9; start = 1'b1;   // R7, R9
      end
      if (disturb && cycles == 3) start = 1'b0;
      @(negedge clk);
      cycles++;
    end
    check(samp_seen == s_eff, "R2 sample length", samp_seen, s_eff);
    check(strobes == n_bits, "R5 strobe count", strobes, n_bits);
    check(cycles == s_eff + n_bits + 1, "R8 latency", cycles, s_eff + n_bits + 1);
    check(result == exp_res, "R6 R4 R7 result", result, exp_res);
    check(!busy, "R8 busy low at done", busy, 0);
    @(negedge clk);
    check(!done && !busy, "R8 R9 single done, no extra run", {done, busy}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !sample_phase && !cmp_strobe, "R1 flags in reset",
          {busy, done, sample_phase, cmp_strobe}, 0);
    check(cap_sw == 0 && result == 0, "R1 words in reset", cap_sw | result, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && cap_sw == 0, "R1 idle after reset", {busy, cap_sw}, 0);

    for (int i = 0; i < NV; i++)
      run_conv(VEC[i][21:20], VEC[i][19:12], VEC[i][11:0], VEC[i][22]);

    // reset in the middle of a search
    vin_live = 12'hABC;
    @(negedge clk); start = 1'b1; res_sel = 2'd0; samp_cycles = 8'd1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!busy && !cmp_strobe && cap_sw == 0, "R1 mid-run reset",
          {busy, cmp_strobe, cap_sw}, 0);

    // conversion right after reset still works
    run_conv(2'd0, 8'd2, 12'h001, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule